// File: doc/BRIEF.md
# Audio CPU I/O Register Decoder

This block sits beside a small audio processor that addresses 64 KiB of memory. The sixteen bytes at 0x00F0–0x00FF are claimed by I/O registers: a control byte, an indirect window into the sound chip's register file, four mailbox ports shared with a host processor, and two general scratch bytes. The block decodes each CPU access to that window and returns the read data. Every CPU write is also passed to the backing RAM, whatever its address.

Four mailbox ports carry data in each direction. The host fills the inbound latches through its own port, and the CPU reads them at 0xF4–0xF7. The CPU fills separate outbound latches at the same offsets, and the host reads those back. Two control bits let the CPU wipe the inbound latches two ports at a time.

A third control bit maps a 64-byte boot ROM over the top of memory. While the ROM is mapped, reads of that area see the ROM, and writes to it still reach the RAM underneath. The sound chip is reached through an address byte and a data byte. The sound chip has only 128 registers, so reads use the low seven address bits and writes to higher addresses are dropped.

Top module: `audio_io_regs`

## Requirements
- R1: Every CPU write (`cpu_wr`=1) drives `ram_we`=1 with `ram_addr`=`cpu_addr` and `ram_wdata`=`cpu_wdata` in the same cycle. This holds at register offsets and in the ROM area while the ROM is mapped.
- R2: A CPU write to 0xF1 with bit 4 set zeroes inbound ports 0 and 1 at that clock edge. Bit 5 does the same for ports 2 and 3. A host write to a port of a group cleared in the same cycle leaves that port at 0.
- R3: Bit 7 of a write to 0xF1 sets whether the ROM is mapped. While it is mapped, reads of 0xFFC0–0xFFFF return ROM byte i = (29·i + 0x4B) mod 256, where i = address[5:0]. While it is not mapped, those reads return `ram_rdata`.
- R4: A write to 0xF2 stores the sound-chip address byte, and reading 0xF2 returns the full stored byte.
- R5: `dsp_addr` always equals the low 7 bits of the stored address byte, and a read of 0xF3 returns `dsp_rdata`.
- R6: A CPU write to 0xF3 pulses `dsp_we` with `dsp_wdata`=`cpu_wdata` only when the stored address byte is at most 0x7F. Otherwise `dsp_we` stays 0.
- R7: 0xF8 and 0xF9 are independent read/write bytes.
- R8: A CPU read of 0xF4+k returns the last value the host wrote to port k. A CPU write to 0xF4+k sets outbound latch k, which appears on `host_rdata` when `host_addr`=k. The two directions never affect each other.
- R9: After reset the ROM is mapped, and all inbound and outbound latches, the sound-chip address byte and the scratch bytes are 0.
- R10: Reads of 0xF0, 0xF1 and 0xFA–0xFF return 0. Reads of any other address outside the register window and the mapped ROM return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| ram_we | output | 1 | Backing RAM write enable |
| ram_addr | output | 16 | Backing RAM address |
| ram_wdata | output | 8 | Backing RAM write data |
| ram_rdata | input | 8 | Backing RAM read data |
| dsp_addr | output | 7 | Sound-chip register index |
| dsp_we | output | 1 | Sound-chip register write strobe |
| dsp_wdata | output | 8 | Sound-chip register write data |
| dsp_rdata | input | 8 | Sound-chip register read data |
| host_addr | input | 2 | Host port select |
| host_we | input | 1 | Host write strobe to an inbound latch |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Outbound latch selected by host_addr |

## Verification
The bench drives a host write and a clearing control write in the same cycle. A design that lets the host write win would leave a stale nonzero byte in a port that should read 0. It sets the sound-chip address above 0x7F before writing through 0xF3: a missing drop would corrupt register `addr & 0x7F`, and a missing read mask would present an 8-bit index. It also checks writes into the ROM area while the ROM is mapped, and unmaps the ROM to read the RAM beneath. A block that suppresses the RAM write or keeps serving the ROM is caught there. Random traffic mixes host writes and CPU writes to every offset, to catch an inbound latch that is mirrored into the outbound path, or the reverse.

// File: rtl/aio_pkg.sv
package aio_pkg;
    localparam int DW       = 8;
    localparam int NPORT    = 4;
    localparam int PIW      = $clog2(NPORT);
    localparam int DSP_AW   = 7;
    localparam int NSCR     = 2;

    localparam logic [3:0] OFF_CTRL  = 4'h1;
    localparam logic [3:0] OFF_DADDR = 4'h2;
    localparam logic [3:0] OFF_DDATA = 4'h3;
    localparam logic [3:0] OFF_SCR0  = 4'h8;
    localparam logic [3:0] OFF_SCR1  = 4'h9;

    localparam int CLR_LO_BIT = 4;
    localparam int CLR_HI_BIT = 5;
    localparam int ROM_EN_BIT = 7;

    typedef logic [DW-1:0] byte_t;
    typedef logic [NPORT-1:0][DW-1:0] port_arr_t;

    typedef struct packed {
        logic           sel_reg;
        logic [3:0]     off;
        logic           in_rom;
        logic           wr_ctrl;
        logic           wr_daddr;
        logic           wr_ddata;
        logic           wr_port;
        logic [PIW-1:0] port_idx;
        logic           wr_scr;
        logic           scr_idx;
    } dec_t;

    typedef struct packed {
        port_arr_t in_lat;
        port_arr_t out_lat;
    } mbx_t;

    typedef struct packed {
        logic                      rom_en;
        byte_t                     daddr;
        logic [NSCR-1:0][DW-1:0]   scr;
    } ctl_t;
endpackage

// File: rtl/aio_decode.sv
module aio_decode
    import aio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output dec_t              dec
);
    localparam int ROM_BASE = (1 << ADDR_W) - ROM_BYTES;

    always_comb begin
        dec          = '0;
        dec.sel_reg  = (addr[ADDR_W-1:4] == {{(ADDR_W-8){1'b0}}, 4'hF});
        dec.off      = addr[3:0];
        dec.in_rom   = (addr >= ADDR_W'(ROM_BASE));
        dec.port_idx = addr[PIW-1:0];
        dec.scr_idx  = addr[0];
        if (wr && dec.sel_reg) begin
            dec.wr_ctrl  = (addr[3:0] == OFF_CTRL);
            dec.wr_daddr = (addr[3:0] == OFF_DADDR);
            dec.wr_ddata = (addr[3:0] == OFF_DDATA);
            dec.wr_port  = (addr[3:2] == 2'b01);
            dec.wr_scr   = (addr[3:1] == 3'b100);
        end
    end
endmodule

// File: rtl/aio_mailbox.sv
module aio_mailbox
    import aio_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_we,
    input  logic [PIW-1:0] host_addr,
    input  byte_t          host_wdata,
    input  logic           clr_lo,
    input  logic           clr_hi,
    input  logic           cpu_port_we,
    input  logic [PIW-1:0] cpu_port_idx,
    input  byte_t          cpu_wdata,
    output port_arr_t      in_lat,
    output byte_t          host_rdata
);
    mbx_t mbx_d, mbx_q;

    always_comb begin
        mbx_d = mbx_q;
        if (host_we)
            mbx_d.in_lat[host_addr] = host_wdata;
        for (int i = 0; i < NPORT; i++) begin
            if ((i < NPORT/2) ? clr_lo : clr_hi)
                mbx_d.in_lat[i] = '0;
        end
        if (cpu_port_we)
            mbx_d.out_lat[cpu_port_idx] = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mbx_q <= '0;
        else        mbx_q <= mbx_d;
    end

    assign in_lat     = mbx_q.in_lat;
    assign host_rdata = mbx_q.out_lat[host_addr];

    for (genvar g = 0; g < NPORT; g++) begin : g_port_chk
        localparam bit LO = (g < NPORT/2);
        // R2: a clear of the group wins over everything
        p_port_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (LO ? clr_lo : clr_hi) |=> (mbx_q.in_lat[g] == '0));
        // R8: host write lands when not cleared
        p_host_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && host_addr == PIW'(g) && !(LO ? clr_lo : clr_hi))
            |=> (mbx_q.in_lat[g] == $past(host_wdata)));
        // R8: CPU port writes never touch the inbound side
        p_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!host_we && !clr_lo && !clr_hi) |=> $stable(mbx_q.in_lat[g]));
    end
endmodule

// File: rtl/aio_boot_rom.sv
module aio_boot_rom
    import aio_pkg::*;
#(
    parameter int ROM_BYTES = 64,
    parameter int IDX_W     = $clog2(ROM_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    output byte_t            data
);
    function automatic byte_t rom_byte(input int unsigned i);
        int unsigned v;
        v = i * 29 + 75;
        return byte_t'(v);
    endfunction

    assign data = rom_byte(int'(idx));
endmodule

// File: rtl/audio_io_regs.sv
module audio_io_regs
    import aio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic [6:0]        dsp_addr,
    output logic              dsp_we,
    output logic [7:0]        dsp_wdata,
    input  logic [7:0]        dsp_rdata,
    input  logic [1:0]        host_addr,
    input  logic              host_we,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    localparam int IDX_W = $clog2(ROM_BYTES);

    dec_t      dec;
    ctl_t      ctl_d, ctl_q;
    port_arr_t in_lat;
    byte_t     rom_data;
    logic      clr_lo, clr_hi;

    aio_decode #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_dec (
        .addr (cpu_addr),
        .wr   (cpu_wr),
        .dec  (dec)
    );

    assign clr_lo = dec.wr_ctrl && cpu_wdata[CLR_LO_BIT];
    assign clr_hi = dec.wr_ctrl && cpu_wdata[CLR_HI_BIT];

    aio_mailbox u_mbx (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .clr_lo       (clr_lo),
        .clr_hi       (clr_hi),
        .cpu_port_we  (dec.wr_port),
        .cpu_port_idx (dec.port_idx),
        .cpu_wdata    (cpu_wdata),
        .in_lat       (in_lat),
        .host_rdata   (host_rdata)
    );

    aio_boot_rom #(.ROM_BYTES(ROM_BYTES), .IDX_W(IDX_W)) u_rom (
        .idx  (cpu_addr[IDX_W-1:0]),
        .data (rom_data)
    );

    // next-state for control, address window and scratch bytes
    always_comb begin
        ctl_d = ctl_q;
        if (dec.wr_ctrl)  ctl_d.rom_en = cpu_wdata[ROM_EN_BIT];
        if (dec.wr_daddr) ctl_d.daddr  = cpu_wdata;
        if (dec.wr_scr)   ctl_d.scr[dec.scr_idx] = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.rom_en <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // RAM sees every write
    assign ram_we    = cpu_wr;
    assign ram_addr  = cpu_addr;
    assign ram_wdata = cpu_wdata;

    // sound-chip window
    assign dsp_addr  = ctl_q.daddr[DSP_AW-1:0];
    assign dsp_wdata = cpu_wdata;
    assign dsp_we    = dec.wr_ddata && !ctl_q.daddr[DW-1];

    // read mux
    always_comb begin
        cpu_rdata = ram_rdata;
        if (dec.sel_reg) begin
            cpu_rdata = '0;
            unique case (dec.off)
                OFF_DADDR:               cpu_rdata = ctl_q.daddr;
                OFF_DDATA:               cpu_rdata = dsp_rdata;
                4'h4, 4'h5, 4'h6, 4'h7:  cpu_rdata = in_lat[dec.off[PIW-1:0]];
                OFF_SCR0, OFF_SCR1:      cpu_rdata = ctl_q.scr[dec.off[0]];
                default:                 cpu_rdata = '0;
            endcase
        end else if (dec.in_rom && ctl_q.rom_en) begin
            cpu_rdata = rom_data;
        end
    end

    // R3: mapped ROM area serves ROM bytes
    p_rom_serve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.in_rom && ctl_q.rom_en) |-> (cpu_rdata == rom_data));
    // R3: unmapped ROM area falls through to RAM
    p_rom_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.in_rom && !ctl_q.rom_en) |-> (cpu_rdata == ram_rdata));
    // R3: control write sets the overlay from bit 7
    p_overlay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr_ctrl |=> (ctl_q.rom_en == $past(cpu_wdata[ROM_EN_BIT])));
    // R4: address byte changes only on its own write
    p_daddr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.wr_daddr |=> $stable(ctl_q.daddr));
    // R6: no sound-chip write with an out-of-range index
    p_dsp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_we |-> (cpu_wr && !ctl_q.daddr[DW-1]));
endmodule

// File: tb/sim_audio_io_regs.sv
module sim_audio_io_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_wr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [6:0]  dsp_addr;
    logic        dsp_we;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic [1:0]  host_addr;
    logic        host_we;
    logic [7:0]  host_wdata, host_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    bit       m_rom_en;
    bit [7:0] m_daddr;
    bit [7:0] m_scr [2];
    bit [7:0] m_in  [4];
    bit [7:0] m_out [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ram_rdata = ram_addr[15:8] ^ ram_addr[7:0] ^ 8'h5A;
    assign dsp_rdata = {1'b0, dsp_addr} ^ 8'hC6;

    audio_io_regs u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
        .dsp_rdata(dsp_rdata), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic bit [7:0] rom_val(input bit [5:0] i);
        return 8'((int'(i) * 29 + 75) % 256);
    endfunction

    function automatic bit [7:0] exp_read(input bit [15:0] a);
        if (a[15:4] == 12'h00F) begin
            case (a[3:0])
                4'h2: return m_daddr;
                4'h3: return {1'b0, m_daddr[6:0]} ^ 8'hC6;
                4'h4, 4'h5, 4'h6, 4'h7: return m_in[a[1:0]];
                4'h8: return m_scr[0];
                4'h9: return m_scr[1];
                default: return 8'h00;
            endcase
        end
        if (a >= 16'hFFC0 && m_rom_en) return rom_val(a[5:0]);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_rom_en = 1; m_daddr = 0;
        foreach (m_scr[i]) m_scr[i] = 0;
        foreach (m_in[i])  begin m_in[i] = 0; m_out[i] = 0; end
    endtask

    // one cycle with optional cpu write and host write
    task automatic step(input bit cw, input bit [15:0] ca, input bit [7:0] cd,
                        input bit hw, input bit [1:0] ha, input bit [7:0] hd);
        @(negedge clk);
        cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
        host_we = hw; host_addr = ha; host_wdata = hd;
        #1;
        if (cw) begin
            check("R1 ram_we", ram_we, 1);
            check("R1 ram_addr", ram_addr, ca);
            check("R1 ram_wdata", ram_wdata, cd);
            if (ca == 16'h00F3) begin
                check("R6 dsp_we", dsp_we, !m_daddr[7]);
                if (!m_daddr[7]) check("R6 dsp_wdata", dsp_wdata, cd);
            end
        end
        @(posedge clk);
        if (hw) m_in[ha] = hd;
        if (cw && ca[15:4] == 12'h00F) begin
            case (ca[3:0])
                4'h1: begin
                    if (cd[4]) begin m_in[0] = 0; m_in[1] = 0; end
                    if (cd[5]) begin m_in[2] = 0; m_in[3] = 0; end
                    m_rom_en = cd[7];
                end
                4'h2: m_daddr = cd;
                4'h4, 4'h5, 4'h6, 4'h7: m_out[ca[1:0]] = cd;
                4'h8: m_scr[0] = cd;
                4'h9: m_scr[1] = cd;
                default: ;
            endcase
        end
        @(negedge clk);
        cpu_wr = 0; host_we = 0;
    endtask

    task automatic rd(input string tag, input bit [15:0] a);
        @(negedge clk);
        cpu_wr = 0; host_we = 0; cpu_addr = a;
        #1;
        check(tag, cpu_rdata, exp_read(a));
    endtask

    task automatic hrd(input string tag, input bit [1:0] k);
        @(negedge clk);
        host_we = 0; host_addr = k;
        #1;
        check(tag, host_rdata, m_out[k]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
        host_we = 0; host_addr = 0; host_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R9 reset state
        rd("R9 rom mapped", 16'hFFC0);
        rd("R9 rom mapped top", 16'hFFFF);
        for (int k = 0; k < 4; k++) begin
            rd("R9 in latch", 16'h00F4 + 16'(k));
            hrd("R9 out latch", 2'(k));
        end
        rd("R9 daddr", 16'h00F2);
        rd("R9 scratch", 16'h00F8);

        // R10 unused offsets and plain RAM
        rd("R10 F0", 16'h00F0);
        rd("R10 F1", 16'h00F1);
        rd("R10 FA", 16'h00FA);
        rd("R10 FF", 16'h00FF);
        rd("R10 ram", 16'h1234);
        rd("R10 ram below rom", 16'hFFBF);

        // R1 write into mapped ROM area still reaches RAM, read stays ROM
        step(1, 16'hFFC7, 8'hEE, 0, 0, 0);
        rd("R3 rom after write", 16'hFFC7);

        // R8 both directions
        step(0, 0, 0, 1, 2'd2, 8'hA7);
        step(1, 16'h00F6, 8'h3C, 0, 0, 0);
        rd("R8 cpu sees host", 16'h00F6);
        hrd("R8 host sees cpu", 2'd2);

        // R2 clear collides with host write to port 1
        step(0, 0, 0, 1, 2'd0, 8'h11);
        step(0, 0, 0, 1, 2'd3, 8'h33);
        step(1, 16'h00F1, 8'h90, 1, 2'd1, 8'h55);
        rd("R2 port0 cleared", 16'h00F4);
        rd("R2 port1 clear wins", 16'h00F5);
        rd("R2 port3 kept", 16'h00F7);
        rd("R3 rom still mapped", 16'hFFD0);
        step(1, 16'h00F1, 8'h20, 0, 0, 0);
        rd("R2 port3 cleared", 16'h00F7);
        rd("R3 rom unmapped", 16'hFFC7);
        hrd("R2 out untouched", 2'd2);

        // R4 R5 R6 sound-chip window
        step(1, 16'h00F2, 8'h9A, 0, 0, 0);
        rd("R4 daddr readback", 16'h00F2);
        check("R5 dsp_addr masked", dsp_addr, 7'h1A);
        rd("R5 dsp read", 16'h00F3);
        step(1, 16'h00F3, 8'h77, 0, 0, 0);
        step(1, 16'h00F2, 8'h7F, 0, 0, 0);
        step(1, 16'h00F3, 8'h66, 0, 0, 0);

        // R7 scratch
        step(1, 16'h00F8, 8'hC1, 0, 0, 0);
        step(1, 16'h00F9, 8'h2D, 0, 0, 0);
        rd("R7 scratch0", 16'h00F8);
        rd("R7 scratch1", 16'h00F9);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            bit cw, hw;
            bit [15:0] ca, ra;
            cw = ($urandom % 3) != 0;
            hw = ($urandom % 2) != 0;
            ca = 16'h00F0 + 16'($urandom % 16);
            if ($urandom % 8 == 0) ca = 16'($urandom);
            step(cw, ca, 8'($urandom), hw, 2'($urandom), 8'($urandom));
            case ($urandom % 3)
                0: ra = 16'h00F0 + 16'($urandom % 16);
                1: ra = 16'hFFC0 + 16'($urandom % 64);
                default: ra = 16'($urandom);
            endcase
            rd("R8 R3 R10 random read", ra);
            rd("R8 random port read", 16'h00F4 + 16'($urandom % 4));
            hrd("R8 random host read", 2'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule